// File: doc/BRIEF.md
# Key Store Access Guard

This block stands between a crypto engine and its two private key sources. One source is a set of three fuse-backed keys, wired straight to the engine: a storage key, a device-unique key and a root storage key. The other is a key SRAM that holds three regions of decrypted working keys, for content protection, encryption and secure boot. The guard keeps the engine's security state. It checks every fuse read, every key SRAM read attempt and every AES result write against that state, and it answers each request one cycle later with registered grant, deny, strobe and address outputs.

The engine sets its state with a configuration beat that carries a secure bit and a root-key bit. The root-key bit selects the mode in which AES decrypts with the root storage key. That mode exists to unwrap encrypted working keys fetched from external memory. While it is active, AES results may land only inside a defined key SRAM region and never in external memory. The engine can never read the key SRAM back. Each refused access sets a sticky violation flag, which only reset clears.

Top module: `keystore_access_guard`

## Requirements
- R1: After reset, secure mode and root mode are inactive, the violation flag is 0, and every grant, deny, strobe, address, region and key output is 0.
- R2: In secure mode, a fuse read with selector 0 (storage key), 1 (unique key) or 2 (root key) sets `fuse_rd_grant` one cycle later, and `fuse_key_out` then carries the selected key.
- R3: A fuse read in non-secure mode, or one with the reserved selector 3, sets `fuse_rd_deny` one cycle later, leaves `fuse_key_out` at 0 and sets the violation flag.
- R4: A key SRAM read request is always refused: `ksram_rd_deny` rises one cycle later and the violation flag is set.
- R5: A configuration beat with the root bit 1 and the secure bit 0 leaves root mode off and sets the violation flag. After it, a key SRAM write at an in-region address (0x20) is blocked.
- R6: In root mode, a write aimed at external memory (`wr_to_ksram`=0) is blocked: `wr_block`=1, both strobes 0, address 0, violation set.
- R7: In root mode, a key SRAM write inside a region gives `wr_strobe_ksram`=1 one cycle later, with `wr_addr_out` equal to the request address and `wr_region` equal to the region index. The regions are 0x00-0x3F (0), 0x40-0x4F (1) and 0x50-0x5F (2).
- R8: In root mode, a key SRAM write at an address outside all three regions is blocked and flagged.
- R9: Outside root mode, every key SRAM write is blocked and flagged.
- R10: Outside root mode, a write aimed at external memory is granted: `wr_strobe_ext`=1 and `wr_addr_out` equals the request address.
- R11: The violation flag stays set through any later legal traffic until reset.
- R12: A configuration beat with the secure bit 0 also clears root mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Mode configuration beat |
| cfg_secure | input | 1 | Requested secure mode |
| cfg_root | input | 1 | Requested root-key decrypt mode |
| fuse_key_a | input | KW | Fuse storage key (selector 0) |
| fuse_key_b | input | KW | Fuse unique key (selector 1) |
| fuse_key_c | input | KW | Fuse root key (selector 2) |
| fuse_rd_req | input | 1 | Fuse key read request |
| fuse_rd_sel | input | 2 | Fuse key selector |
| ksram_rd_req | input | 1 | Key SRAM read attempt from the engine |
| wr_req | input | 1 | AES result write beat |
| wr_to_ksram | input | 1 | 1: target key SRAM, 0: external memory |
| wr_addr | input | AW | Requested write address |
| fuse_rd_grant | output | 1 | Fuse read granted |
| fuse_rd_deny | output | 1 | Fuse read refused |
| fuse_key_out | output | KW | Granted key value, 0 otherwise |
| ksram_rd_deny | output | 1 | Key SRAM read refused |
| wr_strobe_ksram | output | 1 | Key SRAM write strobe |
| wr_strobe_ext | output | 1 | External write strobe |
| wr_block | output | 1 | Write beat blocked |
| wr_addr_out | output | AW | Final write address on a granted beat, else 0 |
| wr_region | output | RIW | Key region hit by a key SRAM write |
| violation | output | 1 | Sticky violation flag |

## Verification
On every cycle, the checker confirms several properties. A fuse grant or an external strobe never follows a forbidden state, and root mode never exists without secure mode. At most one write outcome is active, a refused access is always matched by the violation flag, and the flag never falls outside reset. Only the bench's scenarios can show the rest: which key value appears for each selector, where the region edges lie and which index each region gets, and that a forbidden configuration beat really leaves root mode off.

// File: rtl/ksg_pkg.sv
package ksg_pkg;
  typedef enum logic [1:0] {
    FK_STORE  = 2'd0,
    FK_UNIQUE = 2'd1,
    FK_ROOT   = 2'd2,
    FK_RSVD   = 2'd3
  } fuse_sel_e;
endpackage

// File: rtl/ksg_mode_ctrl.sv
module ksg_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cfg_valid,
  input  logic cfg_secure,
  input  logic cfg_root,
  output logic secure_q,
  output logic root_q,
  output logic bad_select
);
  // root mode only ever lives inside secure mode
  always_ff @(posedge clk) begin
    if (rst) begin
      secure_q <= 1'b0;
      root_q   <= 1'b0;
    end else if (cfg_valid) begin
      secure_q <= cfg_secure;
      root_q   <= cfg_secure & cfg_root;
    end
  end

  assign bad_select = cfg_valid & cfg_root & ~cfg_secure;
endmodule

// File: rtl/ksg_fuse_gate.sv
module ksg_fuse_gate
  import ksg_pkg::*;
#(
  parameter int KW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          secure,
  input  logic          rd_req,
  input  logic [1:0]    rd_sel,
  input  logic [KW-1:0] key_a,
  input  logic [KW-1:0] key_b,
  input  logic [KW-1:0] key_c,
  output logic          grant,
  output logic          deny,
  output logic [KW-1:0] key_out,
  output logic          deny_evt
);
  fuse_sel_e     sel;
  logic          ok;
  logic [KW-1:0] key_mux;

  assign sel      = fuse_sel_e'(rd_sel);
  assign ok       = rd_req & secure & (sel != FK_RSVD);
  assign deny_evt = rd_req & ~ok;

  always_comb begin
    unique case (sel)
      FK_STORE:  key_mux = key_a;
      FK_UNIQUE: key_mux = key_b;
      FK_ROOT:   key_mux = key_c;
      default:   key_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant   <= 1'b0;
      deny    <= 1'b0;
      key_out <= '0;
    end else begin
      grant   <= ok;
      deny    <= deny_evt;
      key_out <= ok ? key_mux : '0;
    end
  end
endmodule

// File: rtl/ksg_region_dec.sv
module ksg_region_dec #(
  parameter int                  AW    = 8,
  parameter int                  NREG  = 3,
  parameter logic [NREG*AW-1:0]  BASES = {8'h50, 8'h40, 8'h00},
  parameter logic [NREG*AW-1:0]  LASTS = {8'h5F, 8'h4F, 8'h3F},
  localparam int                 IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [NREG-1:0] hit_v;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_cmp
      assign hit_v[g] = (addr >= BASES[g*AW +: AW]) && (addr <= LASTS[g*AW +: AW]);
    end
  endgenerate

  // lowest region index wins if ranges overlap
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ksg_write_gate.sv
module ksg_write_gate #(
  parameter int AW  = 8,
  parameter int IW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          root,
  input  logic          wr_req,
  input  logic          to_ksram,
  input  logic [AW-1:0] addr,
  input  logic          reg_hit,
  input  logic [IW-1:0] reg_idx,
  output logic          strobe_ksram,
  output logic          strobe_ext,
  output logic          block,
  output logic [AW-1:0] addr_out,
  output logic [IW-1:0] region,
  output logic          block_evt
);
  logic ok_ks, ok_ext;

  // key SRAM only under root mode and inside a region; external never under root mode
  assign ok_ks     = wr_req & to_ksram & root & reg_hit;
  assign ok_ext    = wr_req & ~to_ksram & ~root;
  assign block_evt = wr_req & ~ok_ks & ~ok_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_ksram <= 1'b0;
      strobe_ext   <= 1'b0;
      block        <= 1'b0;
      addr_out     <= '0;
      region       <= '0;
    end else begin
      strobe_ksram <= ok_ks;
      strobe_ext   <= ok_ext;
      block        <= block_evt;
      addr_out     <= (ok_ks | ok_ext) ? addr : '0;
      region       <= ok_ks ? reg_idx : '0;
    end
  end
endmodule

// File: rtl/keystore_access_guard.sv
module keystore_access_guard #(
  parameter int                 KW    = 128,
  parameter int                 AW    = 8,
  parameter int                 NREG  = 3,
  parameter logic [NREG*AW-1:0] BASES = {8'h50, 8'h40, 8'h00},
  parameter logic [NREG*AW-1:0] LASTS = {8'h5F, 8'h4F, 8'h3F},
  localparam int                RIW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_valid,
  input  logic           cfg_secure,
  input  logic           cfg_root,
  input  logic [KW-1:0]  fuse_key_a,
  input  logic [KW-1:0]  fuse_key_b,
  input  logic [KW-1:0]  fuse_key_c,
  input  logic           fuse_rd_req,
  input  logic [1:0]     fuse_rd_sel,
  input  logic           ksram_rd_req,
  input  logic           wr_req,
  input  logic           wr_to_ksram,
  input  logic [AW-1:0]  wr_addr,
  output logic           fuse_rd_grant,
  output logic           fuse_rd_deny,
  output logic [KW-1:0]  fuse_key_out,
  output logic           ksram_rd_deny,
  output logic           wr_strobe_ksram,
  output logic           wr_strobe_ext,
  output logic           wr_block,
  output logic [AW-1:0]  wr_addr_out,
  output logic [RIW-1:0] wr_region,
  output logic           violation
);
  logic           secure_q, root_q, bad_select;
  logic           fuse_deny_evt, wr_block_evt;
  logic           reg_hit;
  logic [RIW-1:0] reg_idx;

  ksg_mode_ctrl u_mode (
    .clk        (clk),
    .rst        (rst),
    .cfg_valid  (cfg_valid),
    .cfg_secure (cfg_secure),
    .cfg_root   (cfg_root),
    .secure_q   (secure_q),
    .root_q     (root_q),
    .bad_select (bad_select)
  );

  ksg_fuse_gate #(.KW(KW)) u_fuse (
    .clk      (clk),
    .rst      (rst),
    .secure   (secure_q),
    .rd_req   (fuse_rd_req),
    .rd_sel   (fuse_rd_sel),
    .key_a    (fuse_key_a),
    .key_b    (fuse_key_b),
    .key_c    (fuse_key_c),
    .grant    (fuse_rd_grant),
    .deny     (fuse_rd_deny),
    .key_out  (fuse_key_out),
    .deny_evt (fuse_deny_evt)
  );

  ksg_region_dec #(.AW(AW), .NREG(NREG), .BASES(BASES), .LASTS(LASTS)) u_dec (
    .addr (wr_addr),
    .hit  (reg_hit),
    .idx  (reg_idx)
  );

  ksg_write_gate #(.AW(AW), .IW(RIW)) u_wr (
    .clk          (clk),
    .rst          (rst),
    .root         (root_q),
    .wr_req       (wr_req),
    .to_ksram     (wr_to_ksram),
    .addr         (wr_addr),
    .reg_hit      (reg_hit),
    .reg_idx      (reg_idx),
    .strobe_ksram (wr_strobe_ksram),
    .strobe_ext   (wr_strobe_ext),
    .block        (wr_block),
    .addr_out     (wr_addr_out),
    .region       (wr_region),
    .block_evt    (wr_block_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ksram_rd_deny <= 1'b0;
      violation     <= 1'b0;
    end else begin
      ksram_rd_deny <= ksram_rd_req;
      violation     <= violation | fuse_deny_evt | ksram_rd_req | wr_block_evt | bad_select;
    end
  end
endmodule

// File: rtl/ksg_checker.sv
module ksg_checker #(
  parameter int KW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          ksram_rd_req,
  input logic          fuse_rd_grant,
  input logic          fuse_rd_deny,
  input logic [KW-1:0] fuse_key_out,
  input logic          ksram_rd_deny,
  input logic          wr_strobe_ksram,
  input logic          wr_strobe_ext,
  input logic          wr_block,
  input logic          violation,
  input logic          secure_q,
  input logic          root_q
);
  AST_GRANT_NEEDS_SECURE: assert property (@(posedge clk) disable iff (rst)
    fuse_rd_grant |-> $past(secure_q)); // R2
  AST_KEY_ZERO_UNLESS_GRANT: assert property (@(posedge clk) disable iff (rst)
    !fuse_rd_grant |-> (fuse_key_out == '0)); // R3
  AST_KSRAM_READ_REFUSED: assert property (@(posedge clk) disable iff (rst)
    ksram_rd_req |=> (ksram_rd_deny && violation)); // R4
  AST_ROOT_IMPLIES_SECURE: assert property (@(posedge clk) disable iff (rst)
    root_q |-> secure_q); // R5
  AST_NO_EXT_UNDER_ROOT: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_ext |-> !$past(root_q)); // R6
  AST_KS_WRITE_NEEDS_ROOT: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_ksram |-> $past(root_q)); // R9
  AST_ONE_WRITE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_strobe_ksram, wr_strobe_ext, wr_block})); // R7
  AST_DENY_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (wr_block || fuse_rd_deny || ksram_rd_deny) |-> violation); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation); // R11
endmodule

bind keystore_access_guard ksg_checker #(.KW(KW)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .ksram_rd_req    (ksram_rd_req),
  .fuse_rd_grant   (fuse_rd_grant),
  .fuse_rd_deny    (fuse_rd_deny),
  .fuse_key_out    (fuse_key_out),
  .ksram_rd_deny   (ksram_rd_deny),
  .wr_strobe_ksram (wr_strobe_ksram),
  .wr_strobe_ext   (wr_strobe_ext),
  .wr_block        (wr_block),
  .violation       (violation),
  .secure_q        (secure_q),
  .root_q          (root_q)
);

// File: tb/keystore_access_guard_test.sv
module keystore_access_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 128;
  localparam int AW = 8;
  localparam logic [KW-1:0] KA = {4{32'h1111_A0A0}};
  localparam logic [KW-1:0] KB = {4{32'h2222_B1B1}};
  localparam logic [KW-1:0] KC = {4{32'h3333_C2C2}};

  // {req[3:0], mode[1:0] (0 nonsecure,1 secure,2 root), to_ksram, addr[7:0], outcome[1:0] (0 block,1 ksram,2 ext), region[1:0]}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {4'd10, 2'd0, 1'b0, 8'h33, 2'd2, 2'd0},  // R10
    {4'd9,  2'd0, 1'b1, 8'h10, 2'd0, 2'd0},  // R9
    {4'd10, 2'd1, 1'b0, 8'hA0, 2'd2, 2'd0},  // R10
    {4'd9,  2'd1, 1'b1, 8'h20, 2'd0, 2'd0},  // R9
    {4'd6,  2'd2, 1'b0, 8'h10, 2'd0, 2'd0},  // R6
    {4'd7,  2'd2, 1'b1, 8'h00, 2'd1, 2'd0},  // R7
    {4'd7,  2'd2, 1'b1, 8'h3F, 2'd1, 2'd0},  // R7
    {4'd7,  2'd2, 1'b1, 8'h40, 2'd1, 2'd1},  // R7
    {4'd7,  2'd2, 1'b1, 8'h4F, 2'd1, 2'd1},  // R7
    {4'd7,  2'd2, 1'b1, 8'h5F, 2'd1, 2'd2},  // R7
    {4'd8,  2'd2, 1'b1, 8'h60, 2'd0, 2'd0},  // R8
    {4'd8,  2'd2, 1'b1, 8'hFF, 2'd0, 2'd0}   // R8
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_valid = 0, cfg_secure = 0, cfg_root = 0;
  logic fuse_rd_req = 0, ksram_rd_req = 0, wr_req = 0, wr_to_ksram = 0;
  logic [1:0] fuse_rd_sel = 0;
  logic [AW-1:0] wr_addr = 0;
  logic fuse_rd_grant, fuse_rd_deny, ksram_rd_deny;
  logic wr_strobe_ksram, wr_strobe_ext, wr_block, violation;
  logic [KW-1:0] fuse_key_out;
  logic [AW-1:0] wr_addr_out;
  logic [1:0] wr_region;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keystore_access_guard uut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_secure(cfg_secure), .cfg_root(cfg_root),
    .fuse_key_a(KA), .fuse_key_b(KB), .fuse_key_c(KC),
    .fuse_rd_req(fuse_rd_req), .fuse_rd_sel(fuse_rd_sel), .ksram_rd_req(ksram_rd_req),
    .wr_req(wr_req), .wr_to_ksram(wr_to_ksram), .wr_addr(wr_addr),
    .fuse_rd_grant(fuse_rd_grant), .fuse_rd_deny(fuse_rd_deny), .fuse_key_out(fuse_key_out),
    .ksram_rd_deny(ksram_rd_deny), .wr_strobe_ksram(wr_strobe_ksram), .wr_strobe_ext(wr_strobe_ext),
    .wr_block(wr_block), .wr_addr_out(wr_addr_out), .wr_region(wr_region), .violation(violation)
  );

  task automatic chk(input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cfg_valid = 0; fuse_rd_req = 0; ksram_rd_req = 0; wr_req = 0;
  endtask

  // drive after a falling edge, sample at the following falling edge
  task automatic do_reset();
    rst = 1; idle();
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic set_mode(input logic sec, input logic root);
    cfg_valid = 1; cfg_secure = sec; cfg_root = root;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic fuse_read(input logic [1:0] sel);
    fuse_rd_req = 1; fuse_rd_sel = sel;
    @(negedge clk);
    fuse_rd_req = 0;
  endtask

  task automatic write_beat(input logic to_ks, input logic [AW-1:0] a);
    wr_req = 1; wr_to_ksram = to_ks; wr_addr = a;
    @(negedge clk);
    wr_req = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 violation", KW'(violation), '0);
    chk("R1 outputs", KW'({fuse_rd_grant, fuse_rd_deny, ksram_rd_deny, wr_strobe_ksram, wr_strobe_ext, wr_block}), '0);
    chk("R1 addr/region/key", KW'(wr_addr_out) | KW'(wr_region) | fuse_key_out, '0);
    write_beat(1'b0, 8'h12); // non-root external: passes only if root mode is off
    chk("R1 root off after reset", KW'(wr_strobe_ext), 1);

    // vector table of write beats, each after a fresh reset and mode beat
    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq; logic [1:0] md, oc, rg; logic tk; logic [7:0] ad;
      string tg;
      {rq, md, tk, ad, oc, rg} = VEC[i];
      tg = $sformatf("R%0d vec%0d", rq, i);
      do_reset();
      set_mode(md != 0, md == 2);
      write_beat(tk, ad);
      chk({tg, " ks"},   KW'(wr_strobe_ksram), KW'(oc == 1));
      chk({tg, " ext"},  KW'(wr_strobe_ext),   KW'(oc == 2));
      chk({tg, " blk"},  KW'(wr_block),        KW'(oc == 0));
      chk({tg, " addr"}, KW'(wr_addr_out),     (oc == 0) ? '0 : KW'(ad));
      chk({tg, " reg"},  KW'(wr_region),       KW'(rg));
      chk({tg, " viol"}, KW'(violation),       KW'(oc == 0));
    end

    // R2 secure fuse reads per selector
    do_reset();
    set_mode(1, 0);
    fuse_read(2'd0); chk("R2 sel0 key", fuse_key_out, KA); chk("R2 sel0 grant", KW'(fuse_rd_grant), 1);
    fuse_read(2'd1); chk("R2 sel1 key", fuse_key_out, KB);
    fuse_read(2'd2); chk("R2 sel2 key", fuse_key_out, KC);
    chk("R2 no violation", KW'(violation), 0);
    // R3 reserved selector
    fuse_read(2'd3);
    chk("R3 rsvd deny", KW'(fuse_rd_deny), 1); chk("R3 rsvd key", fuse_key_out, '0);
    chk("R3 rsvd viol", KW'(violation), 1);
    // R3 non-secure read
    do_reset();
    fuse_read(2'd2);
    chk("R3 nonsecure deny", KW'(fuse_rd_deny), 1); chk("R3 nonsecure grant", KW'(fuse_rd_grant), 0);
    chk("R3 nonsecure key", fuse_key_out, '0); chk("R3 nonsecure viol", KW'(violation), 1);

    // R4 key SRAM read refused even in root mode
    do_reset();
    set_mode(1, 1);
    ksram_rd_req = 1; @(negedge clk); ksram_rd_req = 0;
    chk("R4 deny", KW'(ksram_rd_deny), 1); chk("R4 viol", KW'(violation), 1);

    // R5 root without secure
    do_reset();
    set_mode(0, 1);
    chk("R5 viol", KW'(violation), 1);
    write_beat(1'b1, 8'h20);
    chk("R5 root stays off", KW'(wr_block), 1);

    // R11 sticky across legal traffic
    set_mode(1, 1);
    write_beat(1'b1, 8'h41);
    chk("R11 legal write ok", KW'(wr_strobe_ksram), 1);
    repeat (3) @(negedge clk);
    chk("R11 still set", KW'(violation), 1);

    // R12 dropping secure clears root
    do_reset();
    set_mode(1, 1);
    set_mode(0, 0);
    write_beat(1'b0, 8'h77);
    chk("R12 ext allowed", KW'(wr_strobe_ext), 1);
    chk("R12 addr", KW'(wr_addr_out), KW'(8'h77));
    set_mode(1, 1);
    set_mode(0, 0);
    set_mode(1, 0); // secure back on, root must stay off
    write_beat(1'b1, 8'h05);
    chk("R12 root not restored", KW'(wr_block), 1);

    // R1 reset clears a set flag
    do_reset();
    @(negedge clk);
    chk("R1 flag cleared", KW'(violation), 0);

    summary();
  end
endmodule